// File: doc/BRIEF.md
# Simulation Finisher Register

This block is a small peripheral on a 32-bit APB bus. Test software running on a processor uses it to tell the verification environment that a test is over and whether it passed or failed. Software writes one 32-bit word to the first location of the block's window. The low half of that word holds a status code. The high half holds an exit code. Two status values have meaning: 16'h5555 means the test passed and 16'h3333 means it failed. When one of them is seen, the block latches sticky finish, pass or fail flags and a 16-bit result code. The harness watches these outputs and stops the run.

Any other access is treated as a software mistake and reported on PSLVERR during that transfer. Such accesses are a write to another offset, a partial-strobe write, an unknown status value, or a misaligned read. A sticky error output also records that at least one such access happened, so the harness can fail the run even when the bus master ignores the error response. Every read returns zero. The block decodes a 4 KiB window.

Top module: `sim_finisher`

## Requirements
- R1: After reset, the done, pass, fail, error and result code outputs are all zero.
- R2: A write to offset 0 with PSTRB 4'hF and bits 15:0 equal to 16'h5555 sets done and pass on the clock edge that ends the access phase. The result code becomes 0 whatever bits 31:16 hold, and PSLVERR stays low.
- R3: A write to offset 0 with PSTRB 4'hF and bits 15:0 equal to 16'h3333 sets done and fail on that edge. The result code takes bits 31:16 of the written word, and PSLVERR stays low.
- R4: Before done is set, a write to offset 0 whose bits 15:0 hold any other value drives PSLVERR high in its access phase and sets the error output. It leaves done, pass, fail and the code unchanged.
- R5: A write to any nonzero offset in the window is an error (PSLVERR high, error output set), whether or not done is set, and changes no other state.
- R6: A write whose PSTRB differs from 4'hF is an error and changes no other state, even when its status field is valid.
- R7: Every read returns 0. A read at a word-aligned offset (PADDR[1:0] = 0) completes without error. A read with PADDR[1:0] not zero is an error.
- R8: Once done is set, further full-strobe writes to offset 0 complete without error whatever their data. They leave pass, fail and the code unchanged until reset.
- R9: PREADY is high in every cycle, so each transfer ends in its first access cycle. PSLVERR is only ever high during an access phase.
- R10: The error output stays set until reset. Pass and fail are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Active-low synchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte offset inside the window |
| pwdata | input | 32 | Write data: status in 15:0, exit code in 31:16 |
| pstrb | input | 4 | Byte lane strobes |
| prdata | output | 32 | Read data, always zero |
| pready | output | 1 | Transfer complete, always high |
| pslverr | output | 1 | Error response for the current access phase |
| done_o | output | 1 | Sticky: a valid finish command was received |
| pass_o | output | 1 | Sticky: the test passed |
| fail_o | output | 1 | Sticky: the test failed |
| err_o | output | 1 | Sticky: at least one erroneous access occurred |
| code_o | output | 16 | Latched result code |

## Verification
The embedded properties check the following on every cycle:
- pass and fail are never high together;
- a pass result always carries a zero code;
- a rising fail latches the exit field that was on the bus;
- once done, the outputs are frozen;
- every error response is followed by the sticky error flag;
- the error flag stays set until reset;
- an error response never appears outside an access phase.

Other behaviour depends on which access is made and in what order, so only the bench scenarios can show it. This covers the classification of each access: unknown status, wrong offset, partial strobe, misaligned versus aligned read, and writes after done. It also covers the fact that rejected writes leave no trace. In those scenarios a behavioural model is compared with the outputs on every clock.

// File: rtl/sim_finisher.sv
module sim_finisher #(
  parameter int          ADDR_W    = 12,
  parameter logic [15:0] STAT_PASS = 16'h5555,
  parameter logic [15:0] STAT_FAIL = 16'h3333
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  input  logic [3:0]        pstrb,
  output logic [31:0]       prdata,
  output logic              pready,
  output logic              pslverr,
  output logic              done_o,
  output logic              pass_o,
  output logic              fail_o,
  output logic              err_o,
  output logic [15:0]       code_o
);

  logic        access, at_base, full_word, is_pass, is_fail, wr_ok, bad, take;
  logic [15:0] status, exit_code;

  assign status    = pwdata[15:0];
  assign exit_code = pwdata[31:16];
  assign access    = psel & penable;
  assign at_base   = (paddr == '0);
  assign full_word = &pstrb;
  assign is_pass   = (status == STAT_PASS);
  assign is_fail   = (status == STAT_FAIL);
  assign wr_ok     = at_base & full_word & (done_o | is_pass | is_fail);
  assign bad       = access & (pwrite ? ~wr_ok : (paddr[1:0] != 2'b00));
  assign take      = access & pwrite & wr_ok & ~done_o;

  assign pslverr = bad;
  assign pready  = 1'b1;
  assign prdata  = '0;

  always_ff @(posedge pclk) begin
    if (!presetn) begin
      done_o <= 1'b0;
      pass_o <= 1'b0;
      fail_o <= 1'b0;
      err_o  <= 1'b0;
      code_o <= '0;
    end else begin
      if (bad) err_o <= 1'b1;
      if (take) begin
        done_o <= 1'b1;
        pass_o <= is_pass;
        fail_o <= is_fail;
        code_o <= is_fail ? exit_code : 16'h0000;
      end
    end
  end

  p_pass_code_zero_r2: assert property (@(posedge pclk) disable iff (!presetn)
    pass_o |-> code_o == 16'h0000);

  p_fail_code_r3: assert property (@(posedge pclk) disable iff (!presetn)
    $rose(fail_o) |-> code_o == $past(pwdata[31:16]));

  p_slverr_sets_err_r4: assert property (@(posedge pclk) disable iff (!presetn)
    pslverr |=> err_o);

  p_done_frozen_r8: assert property (@(posedge pclk) disable iff (!presetn)
    done_o |=> done_o && $stable(pass_o) && $stable(fail_o) && $stable(code_o));

  p_slverr_phase_r9: assert property (@(posedge pclk) disable iff (!presetn)
    pslverr |-> psel && penable);

  p_err_sticky_r10: assert property (@(posedge pclk) disable iff (!presetn)
    err_o |=> err_o);

  p_pass_fail_excl_r10: assert property (@(posedge pclk) disable iff (!presetn)
    !(pass_o && fail_o));

endmodule

// File: tb/sim_finisher_bench.sv
`timescale 1ns/1ps
module sim_finisher_bench;
  logic        pclk = 1'b0;
  logic        presetn = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [3:0]  pstrb = '0;
  logic [31:0] prdata;
  logic        pready, pslverr, done_o, pass_o, fail_o, err_o;
  logic [15:0] code_o;

  int    checks = 0, errors = 0;
  string cur_req = "R1";
  bit    m_done = 0, m_pass = 0, m_fail = 0, m_err = 0;
  int    m_code = 0;

  always #2 pclk = ~pclk;

  sim_finisher u_sim_finisher (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .pstrb(pstrb),
    .prdata(prdata), .pready(pready), .pslverr(pslverr),
    .done_o(done_o), .pass_o(pass_o), .fail_o(fail_o), .err_o(err_o),
    .code_o(code_o));

  function automatic bit exp_bad(bit wr, int addr, int strb, int data, bit dn);
    int st = data & 32'hFFFF;
    if (!wr) return (addr % 4) != 0;
    if (addr != 0 || strb != 15) return 1;
    if (dn) return 0;
    return !(st == 32'h5555 || st == 32'h3333);
  endfunction

  always @(posedge pclk) begin
    if (!presetn) begin
      m_done <= 0; m_pass <= 0; m_fail <= 0; m_err <= 0; m_code <= 0;
    end else if (psel && penable) begin
      if (exp_bad(pwrite, int'(paddr), int'(pstrb), int'(pwdata), m_done)) m_err <= 1;
      else if (pwrite && !m_done) begin
        m_done <= 1;
        m_pass <= (pwdata[15:0] == 16'h5555);
        m_fail <= (pwdata[15:0] == 16'h3333);
        m_code <= (pwdata[15:0] == 16'h3333) ? int'(pwdata[31:16]) : 0;
      end
    end
  end

  task automatic check(bit ok, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge pclk) begin
    check(pready == 1'b1, "pready", int'(pready), 1);
    check(done_o == m_done, "done", int'(done_o), int'(m_done));
    check(pass_o == m_pass, "pass", int'(pass_o), int'(m_pass));
    check(fail_o == m_fail, "fail", int'(fail_o), int'(m_fail));
    check(err_o == m_err, "err", int'(err_o), int'(m_err));
    check(int'(code_o) == m_code, "code", int'(code_o), m_code);
  end

  task automatic xfer(bit wr, logic [11:0] a, logic [31:0] d, logic [3:0] s);
    @(negedge pclk);
    psel = 1; penable = 0; pwrite = wr; paddr = a; pwdata = d; pstrb = s;
    #1 check(pslverr == 1'b0, "pslverr in setup (R9)", int'(pslverr), 0);
    @(negedge pclk);
    penable = 1;
    #1;
    check(pslverr == exp_bad(wr, int'(a), int'(s), int'(d), m_done),
          "pslverr", int'(pslverr), int'(exp_bad(wr, int'(a), int'(s), int'(d), m_done)));
    check(pready == 1'b1, "pready in access (R9)", int'(pready), 1);
    if (!wr) check(prdata == 32'h0, "prdata (R7)", int'(prdata), 0);
    @(negedge pclk);
    psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic do_reset();
    @(negedge pclk);
    presetn = 0;
    repeat (2) @(negedge pclk);
    presetn = 1;
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired in %s", cur_req);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cur_req = "R1";
    repeat (3) @(negedge pclk);
    presetn = 1;
    @(negedge pclk);
    check(done_o == 0 && pass_o == 0 && fail_o == 0 && err_o == 0 && code_o == 0,
          "reset state R1", int'({done_o, pass_o, fail_o, err_o}), 0);

    cur_req = "R7";
    xfer(0, 12'h000, 0, 4'h0);
    xfer(0, 12'h004, 0, 4'h0);
    xfer(0, 12'hFFC, 0, 4'h0);
    check(err_o == 0, "aligned reads clean R7", int'(err_o), 0);
    xfer(0, 12'h002, 0, 4'h0);
    check(err_o == 1, "misaligned read error R7", int'(err_o), 1);

    do_reset();
    cur_req = "R5";
    xfer(1, 12'h004, 32'h0000_5555, 4'hF);
    check(done_o == 0 && err_o == 1, "wrong offset R5", int'({done_o, err_o}), 1);
    cur_req = "R6";
    xfer(1, 12'h000, 32'h0000_5555, 4'h3);
    check(done_o == 0, "narrow write R6", int'(done_o), 0);
    cur_req = "R4";
    xfer(1, 12'h000, 32'h0042_1234, 4'hF);
    check(done_o == 0 && code_o == 0, "unknown status R4", int'(done_o), 0);

    do_reset();
    cur_req = "R3";
    xfer(1, 12'h000, 32'hABCD_3333, 4'hF);
    check(fail_o == 1 && code_o == 16'hABCD && err_o == 0, "fail capture R3",
          int'(code_o), 32'hABCD);
    cur_req = "R8";
    xfer(1, 12'h000, 32'h0000_5555, 4'hF);
    xfer(1, 12'h000, 32'h7777_3333, 4'hF);
    xfer(1, 12'h000, 32'h0000_BEEF, 4'hF);
    check(err_o == 0 && pass_o == 0 && code_o == 16'hABCD, "frozen after done R8",
          int'(code_o), 32'hABCD);
    cur_req = "R5";
    xfer(1, 12'h008, 32'h0000_3333, 4'hF);
    check(err_o == 1 && code_o == 16'hABCD, "offset error after done R5", int'(err_o), 1);
    cur_req = "R10";
    repeat (4) @(negedge pclk);
    check(err_o == 1, "error sticky R10", int'(err_o), 1);

    do_reset();
    cur_req = "R2";
    xfer(1, 12'h000, 32'hFFFF_5555, 4'hF);
    check(pass_o == 1 && fail_o == 0 && code_o == 0, "pass code zero R2", int'(code_o), 0);
    cur_req = "R8";
    xfer(1, 12'h000, 32'h1111_3333, 4'hF);
    check(pass_o == 1 && fail_o == 0 && err_o == 0, "no change after pass R8",
          int'({pass_o, fail_o, err_o}), 4);
    cur_req = "R6";
    xfer(1, 12'h000, 32'h0000_5555, 4'hE);
    check(err_o == 1, "narrow write after done R6", int'(err_o), 1);

    repeat (2) @(negedge pclk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule